// File: doc/BRIEF.md
# SD/MMC Host Register Front End

This block is the register-facing part of a simple SD/MMC host controller, attached to a 32-bit memory-mapped bus. Software programs the data buffer base, argument, block geometry and interrupt enables, then writes a packed command word. The block decodes that word into separate fields and hands them to the signalling back end with a single-cycle issue strobe.

The back end reports command completion, data completion, command timeout and response words. The block stores the response words and raises status flags. Card-present and write-protect inputs come from the socket with no clock relation. They are synchronised, shown in a read-only card register, and any change of either one sets its own status flag. A registered, level-sensitive interrupt line is asserted while any enabled status flag is set. Software clears flags by writing ones back to the status register.

Top module: `sdhost_regfront`

## Requirements
- R1: A read strobe at a valid offset returns the addressed register on `bus_rdata` one clock later. The offsets are: status 0x00, enable 0x04, buffer base 0x08, command 0x0C, argument 0x10, response words 0 to 3 at 0x14/0x18/0x1C/0x20, block length 0x24, block count 0x28, card 0x2C. Unused bits and unmapped offsets read as zero.
- R2: Reset clears status, enable, command, argument, buffer base, block length, block count, the response words, `irq` and `cmd_issue`.
- R3: A write to the command offset pulses `cmd_issue` high for exactly one cycle, in the cycle after the write. It also presents the decoded fields: opcode from bits 5:0, open-drain from bit 6, response kind from bits 9:8 (0 none, 1 short, 2 long 136-bit, 3 short no-CRC), busy from bit 11, command class from bits 13:12 (0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data) and read direction from bit 15. The register reads back only those bits (mask 0xBB7F).
- R4: A long response loads all four words, with word 0 holding bits 31:0 and word 3 holding bits 127:96. A short response loads word 0 only and leaves words 1 to 3 unchanged. Bus writes to the response offsets have no effect.
- R5: The status bits are bit 0 command done, bit 1 data done, bit 2 card change and bit 3 command timeout. Each back-end event sets its bit on the next clock.
- R6: A timeout in the same cycle as a command-done sets bit 3 and does not set bit 0.
- R7: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R8: If an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: The card register shows the synchronised present flag at bit 0 and write-protect at bit 1. A change of either input sets status bit 2 within four clocks.
- R10: `irq` is a register that is high one cycle after any status bit is set while its enable bit (same position at 0x04) is set.
- R11: Block length and block count store bits 10:0 of the written word as value-minus-one, drive them on `blk_len_m1` and `blk_cnt_m1`, and read the upper bits as zero.
- R12: The buffer base and argument are full 32-bit read/write registers that drive `buf_base` and `cmd_argument`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| cmd_issue | output | 1 | One-cycle command start pulse |
| cmd_opcode | output | 6 | Decoded opcode |
| cmd_open_drain | output | 1 | Open-drain bus mode |
| cmd_resp_kind | output | 2 | Expected response kind |
| cmd_busy | output | 1 | Busy signalling after response |
| cmd_class | output | 2 | Command class |
| cmd_read_dir | output | 1 | Data flows from the card |
| cmd_argument | output | 32 | Command argument |
| buf_base | output | 32 | Data buffer base address |
| blk_len_m1 | output | BLK_W | Block length minus one |
| blk_cnt_m1 | output | BLK_W | Block count minus one |
| be_cmd_done | input | 1 | Back end: command finished |
| be_data_done | input | 1 | Back end: data finished |
| be_timeout | input | 1 | Back end: command timed out |
| be_resp_valid | input | 1 | Back end: response word load |
| be_resp_long | input | 1 | Response is 136-bit |
| be_resp_data | input | 128 | Response bits |
| card_present_async | input | 1 | Socket card-present, asynchronous |
| card_wp_async | input | 1 | Socket write-protect, asynchronous |
| irq | output | 1 | Level interrupt |

## Verification
Random command words are written and each decoded field is compared with a bench decode of that word. Because the words are random, a swapped or shifted field shows up as a mismatch, and the read-back shows whether the mask keeps the right bits. The status register is driven with random mixes of the three back-end events, random clear masks and random enables, all in the same cycle, and compared with a bench model. This separates clear-only, set-only, event-beats-clear and timeout-suppresses-done, and shows whether `irq` follows the enabled bits. Directed cases cover a long against a short response, ignored response writes, truncation of the block fields, unmapped offsets and a card change on each input.

// File: rtl/sdhost_pkg.sv
package sdhost_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_RESP = 4;
  localparam int NUM_EVT  = 4;
  localparam int EV_CMD   = 0;
  localparam int EV_DATA  = 1;
  localparam int EV_CARD  = 2;
  localparam int EV_TMO   = 3;
  localparam int CMD_W    = 16;
  localparam logic [CMD_W-1:0] CMD_KEEP = 16'hBB7F;

  localparam logic [7:0] OFS_STATUS  = 8'h00;
  localparam logic [7:0] OFS_ENABLE  = 8'h04;
  localparam logic [7:0] OFS_BUFBASE = 8'h08;
  localparam logic [7:0] OFS_CMD     = 8'h0C;
  localparam logic [7:0] OFS_ARG     = 8'h10;
  localparam logic [7:0] OFS_RESP0   = 8'h14;
  localparam logic [7:0] OFS_BLKLEN  = 8'h24;
  localparam logic [7:0] OFS_BLKCNT  = 8'h28;
  localparam logic [7:0] OFS_CARD    = 8'h2C;

  typedef struct packed {
    logic       read_dir;
    logic [1:0] cls;
    logic       busy;
    logic [1:0] resp_kind;
    logic       open_drain;
    logic [5:0] opcode;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_cmd(input logic [CMD_W-1:0] w);
    cmd_fields_t f;
    f.opcode     = w[5:0];
    f.open_drain = w[6];
    f.resp_kind  = w[9:8];
    f.busy       = w[11];
    f.cls        = w[13:12];
    f.read_dir   = w[15];
    return f;
  endfunction
endpackage

// File: rtl/sdhost_cmd_decode.sv
module sdhost_cmd_decode
  import sdhost_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_in,
  input  logic [CMD_W-1:0] word_in,
  output logic             strobe_o,
  output cmd_fields_t      fields_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= 1'b0;
      fields_o <= '0;
    end else begin
      strobe_o <= issue_in;
      if (issue_in) fields_o <= unpack_cmd(word_in);
    end
  end

  assert_issue_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    issue_in |=> strobe_o);
  assert_no_stray_issue_R3: assert property (@(posedge clk) disable iff (rst)
    !issue_in |=> !strobe_o);
endmodule

// File: rtl/sdhost_card_sync.sv
module sdhost_card_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic         change_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign level_o  = chain[STAGES-1];
  assign change_o = |(level_o ^ prev_q);
endmodule

// File: rtl/sdhost_int_status.sv
module sdhost_int_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] clear_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= (flags_o & ~clear_i) | event_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
      event_i[i] |=> flags_o[i]);
    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
      (clear_i[i] && !event_i[i]) |=> !flags_o[i]);
  end
endmodule

// File: rtl/sdhost_regfront.sv
module sdhost_regfront
  import sdhost_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BLK_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic                  cmd_issue,
  output logic [5:0]            cmd_opcode,
  output logic                  cmd_open_drain,
  output logic [1:0]            cmd_resp_kind,
  output logic                  cmd_busy,
  output logic [1:0]            cmd_class,
  output logic                  cmd_read_dir,
  output logic [REG_W-1:0]      cmd_argument,
  output logic [REG_W-1:0]      buf_base,
  output logic [BLK_W-1:0]      blk_len_m1,
  output logic [BLK_W-1:0]      blk_cnt_m1,
  input  logic                  be_cmd_done,
  input  logic                  be_data_done,
  input  logic                  be_timeout,
  input  logic                  be_resp_valid,
  input  logic                  be_resp_long,
  input  logic [NUM_RESP*REG_W-1:0] be_resp_data,
  input  logic                  card_present_async,
  input  logic                  card_wp_async,
  output logic                  irq
);
  localparam int CARD_W = 2;

  logic [NUM_EVT-1:0] en_q, stat_q, evt, clr;
  logic [CMD_W-1:0]   cmdw_q;
  logic [REG_W-1:0]   resp_q [NUM_RESP];
  logic [REG_W-1:0]   rd_mux;
  logic [CARD_W-1:0]  card_lvl;
  logic               card_chg;
  cmd_fields_t        fields;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  wire wr_status = bus_wr_en && hit(bus_addr, OFS_STATUS);
  wire wr_cmd    = bus_wr_en && hit(bus_addr, OFS_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= '0;
      buf_base     <= '0;
      cmdw_q       <= '0;
      cmd_argument <= '0;
      blk_len_m1   <= '0;
      blk_cnt_m1   <= '0;
    end else if (bus_wr_en) begin
      if (hit(bus_addr, OFS_ENABLE))  en_q         <= bus_wdata[NUM_EVT-1:0];
      if (hit(bus_addr, OFS_BUFBASE)) buf_base     <= bus_wdata;
      if (hit(bus_addr, OFS_CMD))     cmdw_q       <= bus_wdata[CMD_W-1:0] & CMD_KEEP;
      if (hit(bus_addr, OFS_ARG))     cmd_argument <= bus_wdata;
      if (hit(bus_addr, OFS_BLKLEN))  blk_len_m1   <= bus_wdata[BLK_W-1:0];
      if (hit(bus_addr, OFS_BLKCNT))  blk_cnt_m1   <= bus_wdata[BLK_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_RESP; i++) begin : g_resp
    always_ff @(posedge clk) begin
      if (rst) resp_q[i] <= '0;
      else if (be_resp_valid && (be_resp_long || i == 0))
        resp_q[i] <= be_resp_data[i*REG_W +: REG_W];
    end
  end

  sdhost_cmd_decode u_dec (
    .clk(clk), .rst(rst), .issue_in(wr_cmd),
    .word_in(bus_wdata[CMD_W-1:0]), .strobe_o(cmd_issue), .fields_o(fields)
  );

  assign cmd_opcode     = fields.opcode;
  assign cmd_open_drain = fields.open_drain;
  assign cmd_resp_kind  = fields.resp_kind;
  assign cmd_busy       = fields.busy;
  assign cmd_class      = fields.cls;
  assign cmd_read_dir   = fields.read_dir;

  sdhost_card_sync #(.W(CARD_W), .STAGES(SYNC_STAGES)) u_card (
    .clk(clk), .rst(rst), .async_i({card_wp_async, card_present_async}),
    .level_o(card_lvl), .change_o(card_chg)
  );

  always_comb begin
    evt          = '0;
    evt[EV_CMD]  = be_cmd_done && !be_timeout;
    evt[EV_DATA] = be_data_done;
    evt[EV_CARD] = card_chg;
    evt[EV_TMO]  = be_timeout;
    clr          = wr_status ? bus_wdata[NUM_EVT-1:0] : '0;
  end

  sdhost_int_status #(.N(NUM_EVT)) u_stat (
    .clk(clk), .rst(rst), .event_i(evt), .clear_i(clr), .flags_o(stat_q)
  );

  always_comb begin
    rd_mux = '0;
    if      (hit(bus_addr, OFS_STATUS))  rd_mux[NUM_EVT-1:0] = stat_q;
    else if (hit(bus_addr, OFS_ENABLE))  rd_mux[NUM_EVT-1:0] = en_q;
    else if (hit(bus_addr, OFS_BUFBASE)) rd_mux = buf_base;
    else if (hit(bus_addr, OFS_CMD))     rd_mux[CMD_W-1:0] = cmdw_q;
    else if (hit(bus_addr, OFS_ARG))     rd_mux = cmd_argument;
    else if (hit(bus_addr, OFS_BLKLEN))  rd_mux[BLK_W-1:0] = blk_len_m1;
    else if (hit(bus_addr, OFS_BLKCNT))  rd_mux[BLK_W-1:0] = blk_cnt_m1;
    else if (hit(bus_addr, OFS_CARD))    rd_mux[CARD_W-1:0] = card_lvl;
    else begin
      for (int i = 0; i < NUM_RESP; i++)
        if (hit(bus_addr, OFS_RESP0 + 8'(4*i))) rd_mux = resp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd_en) bus_rdata <= rd_mux;
      irq <= |(stat_q & en_q);
    end
  end

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & en_q)) |=> irq);
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & en_q)) |=> !irq);
  assert_timeout_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    (be_timeout && !stat_q[EV_CMD] && !evt[EV_CMD]) |=> !stat_q[EV_CMD]);
  assert_timeout_sets_R5: assert property (@(posedge clk) disable iff (rst)
    be_timeout |=> stat_q[EV_TMO]);
  assert_short_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (be_resp_valid && !be_resp_long) |=> $stable(resp_q[NUM_RESP-1]));
  assert_card_event_R9: assert property (@(posedge clk) disable iff (rst)
    card_chg |=> stat_q[EV_CARD]);
  assert_blklen_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && hit(bus_addr, OFS_BLKLEN)) |=> blk_len_m1 == $past(bus_wdata[BLK_W-1:0]));
endmodule

// File: tb/sdhost_regfront_test.sv
module sdhost_regfront_test;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr_en = 0, bus_rd_en = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cmd_issue, cmd_open_drain, cmd_busy, cmd_read_dir, irq;
  logic [5:0] cmd_opcode;
  logic [1:0] cmd_resp_kind, cmd_class;
  logic [31:0] cmd_argument, buf_base;
  logic [10:0] blk_len_m1, blk_cnt_m1;
  logic be_cmd_done = 0, be_data_done = 0, be_timeout = 0, be_resp_valid = 0, be_resp_long = 0;
  logic [127:0] be_resp_data = 0;
  logic card_present_async = 0, card_wp_async = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sdhost_regfront uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1; bus_addr = a;
    @(negedge clk); bus_rd_en = 0; d = bus_rdata;
  endtask

  function automatic logic [31:0] fields_of(input logic [15:0] w);
    return {17'd0, w[15], w[13:12], w[11], w[9:8], w[6], w[5:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [3:0] model, en;
    logic [127:0] resp;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    check("R2 irq", {31'd0, irq}, 0);
    check("R2 issue", {31'd0, cmd_issue}, 0);
    rd(8'h00, d); check("R2 status", d, 0);
    rd(8'h0C, d); check("R2 cmd", d, 0);
    rd(8'h14, d); check("R2 resp0", d, 0);
    check("R2 blklen", {21'd0, blk_len_m1}, 0);

    // R12 base and argument
    wr(8'h08, 32'hDEAD_BEEF); rd(8'h08, d); check("R12 base read", d, 32'hDEAD_BEEF);
    check("R12 base port", buf_base, 32'hDEAD_BEEF);
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); check("R12 arg read", d, 32'h1234_5678);
    check("R12 arg port", cmd_argument, 32'h1234_5678);

    // R11 block fields truncate
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); check("R11 len read", d, 32'h7FF);
    check("R11 len port", {21'd0, blk_len_m1}, 32'h7FF);
    wr(8'h28, 32'h0000_0805); rd(8'h28, d); check("R11 cnt read", d, 32'h005);
    check("R11 cnt port", {21'd0, blk_cnt_m1}, 32'h005);

    // R1 unmapped offset
    rd(8'h30, d); check("R1 unmapped", d, 0);

    // R3 random command words
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w;
      w = 16'($urandom());
      wr(8'h0C, {16'($urandom()), w});
      check("R3 strobe", {31'd0, cmd_issue}, 1);
      check("R3 fields", {17'd0, cmd_read_dir, cmd_class, cmd_busy, cmd_resp_kind,
                          cmd_open_drain, cmd_opcode}, fields_of(w));
      @(negedge clk);
      check("R3 one cycle", {31'd0, cmd_issue}, 0);
      rd(8'h0C, d); check("R3 readback", d, {16'd0, w & 16'hBB7F});
    end

    // R4 responses
    resp = {32'hA3A3_A3A3, 32'hB2B2_B2B2, 32'hC1C1_C1C1, 32'hD0D0_D0D0};
    @(negedge clk); be_resp_valid = 1; be_resp_long = 1; be_resp_data = resp;
    @(negedge clk); be_resp_valid = 0;
    for (int i = 0; i < 4; i++) begin
      rd(8'h14 + 8'(4*i), d); check("R4 long word", d, resp[i*32 +: 32]);
    end
    @(negedge clk); be_resp_valid = 1; be_resp_long = 0; be_resp_data = ~resp;
    @(negedge clk); be_resp_valid = 0;
    rd(8'h14, d); check("R4 short word0", d, ~resp[31:0]);
    rd(8'h18, d); check("R4 short word1 kept", d, resp[63:32]);
    rd(8'h20, d); check("R4 short word3 kept", d, resp[127:96]);
    wr(8'h1C, 32'h0); rd(8'h1C, d); check("R4 write ignored", d, resp[95:64]);

    // R9 card inputs
    wr(8'h04, 32'h4);
    @(negedge clk); card_present_async = 1;
    repeat (4) @(negedge clk);
    rd(8'h00, d); check("R9 change flag", d, 32'h4);
    check("R10 irq on card", {31'd0, irq}, 1);
    rd(8'h2C, d); check("R9 present", d, 32'h1);
    wr(8'h00, 32'h4); rd(8'h00, d); check("R7 clear card", d, 0);
    @(negedge clk); card_wp_async = 1;
    repeat (4) @(negedge clk);
    rd(8'h00, d); check("R9 wp change", d, 32'h4);
    rd(8'h2C, d); check("R9 state", d, 32'h3);
    wr(8'h00, 32'hF);

    // R6 timeout beats done; R8 event beats clear
    @(negedge clk); be_cmd_done = 1; be_timeout = 1;
    @(negedge clk); be_cmd_done = 0; be_timeout = 0;
    rd(8'h00, d); check("R6 timeout only", d, 32'h8);
    wr(8'h00, 32'hF);
    @(negedge clk); be_cmd_done = 1;
    @(negedge clk); be_cmd_done = 0;
    @(negedge clk); be_cmd_done = 1; bus_wr_en = 1; bus_addr = 8'h00; bus_wdata = 32'h1;
    @(negedge clk); be_cmd_done = 0; bus_wr_en = 0;
    rd(8'h00, d); check("R8 event wins", d, 32'h1);

    // R5 R7 R8 R10 random status mix
    model = 4'h1;
    for (int n = 0; n < 60; n++) begin
      logic c, dd, t;
      logic [3:0] cm, ev;
      c = 1'($urandom()); dd = 1'($urandom()); t = 1'($urandom()) & 1'($urandom());
      cm = 4'($urandom()); en = 4'($urandom());
      wr(8'h04, {28'd0, en});
      @(negedge clk);
      be_cmd_done = c; be_data_done = dd; be_timeout = t;
      bus_wr_en = 1; bus_addr = 8'h00; bus_wdata = {28'd0, cm};
      @(negedge clk);
      be_cmd_done = 0; be_data_done = 0; be_timeout = 0; bus_wr_en = 0;
      ev = {t, 1'b0, dd, c & ~t};
      model = (model & ~cm) | ev;
      rd(8'h00, d); check("R5 R7 R8 status model", d, {28'd0, model});
      check("R10 irq model", {31'd0, irq}, {31'd0, |(model & en)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule